// File: doc/BRIEF.md
# Single Cache Line Command Unit

This block carries out one maintenance or debug operation on one line of a two-way cache whose tag, state and data arrays it holds internally. Software programs a control word, a search address and a value word through a small register port. Setting bit 0 of either the control word or the search address word starts a command. The command runs for exactly one cycle. While it runs, bit 0 of both read-back words shows 1.

A line is chosen in one of two ways. In index mode the caller gives an index and a way bit. In search mode the caller gives a physical address, and the block compares its tag against the valid tags of both ways at the addressed index. There are four commands. A search access reads or writes the tag word or the data word of the line. An invalidate drops the line. A push writes a dirty line back and keeps it valid. A clear writes a dirty line back and then drops it. A write-back appears as a one-cycle pulse that carries the line address and its data.

When a command finishes, the block reports the line's valid bit and modified bit as they were before the command, together with the way it used. A search that misses in both ways changes nothing and reports all three status bits as zero.

Top module: `line_cmd_unit`

## Requirements
- R1: A register write with bit 0 set, to the control word (select 0) or to the search address word (select 1), made while the unit is idle, raises `busy` in the next cycle for exactly one cycle. Bit 0 of both read-back words mirrors `busy`.
- R2: Control word fields: command [25:24] (0 search access, 1 invalidate, 2 push, 3 clear), address mode bit 26 (0 index, 1 physical), access bit 27 (0 read, 1 write), array bit 16 (0 data, 1 tag word), way bit 14, index field [13:2] of which only the low IDX_W bits are used. Bits [22:20] are read-only status, and writes to them are ignored.
- R3: A search read loads the value word with the line's data, or with its tag word. The tag word holds the tag in [TAG_W+1:2], the modified bit in bit 1, the valid bit in bit 0, and zeros above.
- R4: A search write stores the value word into the line's data, or, when the tag word is selected, sets tag, modified bit and valid bit from the tag word layout of R3.
- R5: In physical mode the index is address bits [IDX_W+1:2] and the tag is the TAG_W bits above them. The line used is the way whose valid tag matches, and way 0 wins when both match.
- R6: A physical-mode miss in both ways changes no line and no value word, and reports status 000.
- R7: Invalidate clears the line's valid and modified bits and keeps its tag and data.
- R8: Push on a valid, modified line gives one `wb_valid` pulse, in the cycle after execution, with `wb_addr` = {tag, index, 2'b00} and the line's data, then clears the modified bit and keeps the line valid. On any other line there is no pulse.
- R9: Clear writes a valid, modified line back as in R8 and leaves the line invalid and clean in every case.
- R10: On completion, status bits 20, 21 and 22 hold the line's prior valid bit, its prior modified bit and the way used. They hold their value until the next command completes.
- R11: A register write made in the cycle a command is executing is ignored.
- R12: After reset, all lines are invalid and clean, all registers read zero, and `busy` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 search address, 2 value |
| reg_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control word read-back with status and busy |
| srch_rdata | output | 32 | Search address read-back, bit 0 is busy |
| value_rdata | output | 32 | Value word read-back |
| busy | output | 1 | Command executing this cycle |
| wb_valid | output | 1 | Write-back pulse |
| wb_addr | output | 32 | Write-back line address |
| wb_data | output | 32 | Write-back line data |

## Verification
Two things can fall in the same cycle: a host register write and the execution of a command. The write is never stalled. It simply arrives while the unit is writing its own result into the value word and the status bits. The bench provokes this by issuing a value-word write, and in another run a search-address write, in the cycle right after a start. It then judges that the value word holds the command's read result and that the search address is unchanged, both against the reference model on every clock and with directed checks.

// File: rtl/lcu_pkg.sv
package lcu_pkg;

   localparam int NWAY  = 2;
   localparam int WAY_W = 1;

   localparam logic [1:0] SEL_CTRL = 2'd0;
   localparam logic [1:0] SEL_SRCH = 2'd1;
   localparam logic [1:0] SEL_VAL  = 2'd2;

   localparam logic [31:0] CTRL_WMASK = 32'h0F01_7FFC;

   typedef enum logic [1:0] {
      LC_SEARCH = 2'd0,
      LC_INVAL  = 2'd1,
      LC_PUSH   = 2'd2,
      LC_CLEAR  = 2'd3
   } lc_cmd_e;

endpackage

// File: rtl/lcu_regfile.sv
module lcu_regfile
   import lcu_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   input  logic              res_load,
   input  logic [31:0]       res_value,
   input  logic              res_ivb,
   input  logic              res_imb,
   input  logic              res_way,
   output logic              busy,
   output lc_cmd_e           cmd,
   output logic              pmode,
   output logic              acc_wr,
   output logic              tag_sel,
   output logic              way_bit,
   output logic [IDX_W-1:0]  cidx,
   output logic [IDX_W-1:0]  pidx,
   output logic [TAG_W-1:0]  ptag,
   output logic [31:0]       value_q,
   output logic [31:0]       ctrl_rdata,
   output logic [31:0]       srch_rdata
);

   logic [31:0] ctrl_q;
   logic [31:1] srch_q;
   logic [31:0] val_q;
   logic [2:0]  stat_q;
   logic        busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         srch_q <= '0;
         val_q  <= '0;
         stat_q <= '0;
         busy_q <= 1'b0;
      end else if (busy_q) begin
         busy_q <= 1'b0;
         stat_q <= {res_way, res_imb, res_ivb};
         if (res_load) val_q <= res_value;
      end else if (reg_we) begin
         case (reg_sel)
            SEL_CTRL: begin
               ctrl_q <= reg_wdata & CTRL_WMASK;
               busy_q <= reg_wdata[0];
            end
            SEL_SRCH: begin
               srch_q <= reg_wdata[31:1];
               busy_q <= reg_wdata[0];
            end
            SEL_VAL:  val_q <= reg_wdata;
            default:  ;
         endcase
      end
   end

   assign busy    = busy_q;
   assign cmd     = lc_cmd_e'(ctrl_q[25:24]);
   assign pmode   = ctrl_q[26];
   assign acc_wr  = ctrl_q[27];
   assign tag_sel = ctrl_q[16];
   assign way_bit = ctrl_q[14];
   assign cidx    = ctrl_q[2 +: IDX_W];
   assign pidx    = srch_q[2 +: IDX_W];
   assign ptag    = srch_q[IDX_W+2 +: TAG_W];
   assign value_q = val_q;

   assign ctrl_rdata = ctrl_q | {9'b0, stat_q, 19'b0, busy_q};
   assign srch_rdata = {srch_q, busy_q};

endmodule

// File: rtl/lcu_way_store.sv
module lcu_way_store #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   output logic              rd_v,
   output logic              rd_m,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [31:0]       rd_data,
   input  logic              st_we,
   input  logic              st_v,
   input  logic              st_m,
   input  logic              tag_we,
   input  logic [TAG_W-1:0]  tag_wd,
   input  logic              data_we,
   input  logic [31:0]       data_wd
);

   localparam int DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0]            v_q;
   logic [DEPTH-1:0]            m_q;
   logic [DEPTH-1:0][TAG_W-1:0] tag_q;
   logic [DEPTH-1:0][31:0]      data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= '0;
         m_q    <= '0;
         tag_q  <= '0;
         data_q <= '0;
      end else begin
         if (st_we) begin
            v_q[idx] <= st_v;
            m_q[idx] <= st_m;
         end
         if (tag_we)  tag_q[idx]  <= tag_wd;
         if (data_we) data_q[idx] <= data_wd;
      end
   end

   assign rd_v    = v_q[idx];
   assign rd_m    = m_q[idx];
   assign rd_tag  = tag_q[idx];
   assign rd_data = data_q[idx];

endmodule

// File: rtl/lcu_way_pick.sv
module lcu_way_pick #(
   parameter int NWAY  = 2,
   parameter int TAG_W = 8,
   parameter int WAY_W = (NWAY > 1) ? $clog2(NWAY) : 1
) (
   input  logic [NWAY-1:0]            way_v,
   input  logic [NWAY-1:0][TAG_W-1:0] way_tag,
   input  logic [TAG_W-1:0]           key,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);

   logic [NWAY-1:0] match;

   for (genvar w = 0; w < NWAY; w++) begin : g_cmp
      assign match[w] = way_v[w] && (way_tag[w] == key);
   end

   always_comb begin
      hit_way = '0;
      for (int w = NWAY - 1; w >= 0; w--) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit = |match;

endmodule

// File: rtl/line_cmd_unit.sv
module line_cmd_unit
   import lcu_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_sel,
   input  logic [31:0] reg_wdata,
   output logic [31:0] ctrl_rdata,
   output logic [31:0] srch_rdata,
   output logic [31:0] value_rdata,
   output logic        busy,
   output logic        wb_valid,
   output logic [31:0] wb_addr,
   output logic [31:0] wb_data
);

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("line_cmd_unit: IDX_W must lie in 1..12");
   end
   if (IDX_W + TAG_W + 2 > 32 || TAG_W < 1) begin : g_bad_tag
      $error("line_cmd_unit: tag and index do not fit a 32-bit address");
   end

   lc_cmd_e          cmd;
   logic             pmode, acc_wr, tag_sel, way_bit;
   logic [IDX_W-1:0] cidx, pidx, idx;
   logic [TAG_W-1:0] ptag;
   logic [31:0]      value_q;

   logic             res_load;
   logic [31:0]      res_value;

   logic [NWAY-1:0]            w_v, w_m;
   logic [NWAY-1:0][TAG_W-1:0] w_tag;
   logic [NWAY-1:0][31:0]      w_data;

   logic             hit, line_ok;
   logic [WAY_W-1:0] hit_way, sel_way;
   logic             cv, cm;
   logic [TAG_W-1:0] ctag;
   logic [31:0]      cdata, tag_word, line_addr;
   logic             st_we, tag_we, data_we, push_out, nv, nm;

   lcu_regfile #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .res_load   (res_load),
      .res_value  (res_value),
      .res_ivb    (cv),
      .res_imb    (cm),
      .res_way    (sel_way),
      .busy       (busy),
      .cmd        (cmd),
      .pmode      (pmode),
      .acc_wr     (acc_wr),
      .tag_sel    (tag_sel),
      .way_bit    (way_bit),
      .cidx       (cidx),
      .pidx       (pidx),
      .ptag       (ptag),
      .value_q    (value_q),
      .ctrl_rdata (ctrl_rdata),
      .srch_rdata (srch_rdata)
   );

   assign idx = pmode ? pidx : cidx;

   for (genvar w = 0; w < NWAY; w++) begin : g_way
      logic way_act;
      assign way_act = busy && (sel_way == WAY_W'(w));

      lcu_way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .idx     (idx),
         .rd_v    (w_v[w]),
         .rd_m    (w_m[w]),
         .rd_tag  (w_tag[w]),
         .rd_data (w_data[w]),
         .st_we   (way_act && st_we),
         .st_v    (nv),
         .st_m    (nm),
         .tag_we  (way_act && tag_we),
         .tag_wd  (value_q[TAG_W+1:2]),
         .data_we (way_act && data_we),
         .data_wd (value_q)
      );
   end

   lcu_way_pick #(.NWAY(NWAY), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_pick (
      .way_v   (w_v),
      .way_tag (w_tag),
      .key     (ptag),
      .hit     (hit),
      .hit_way (hit_way)
   );

   assign line_ok = pmode ? hit : 1'b1;
   assign sel_way = pmode ? hit_way : way_bit;
   assign cv      = line_ok && w_v[sel_way];
   assign cm      = line_ok && w_m[sel_way];
   assign ctag    = w_tag[sel_way];
   assign cdata   = w_data[sel_way];

   always_comb begin
      tag_word              = '0;
      tag_word[TAG_W+1:2]   = ctag;
      tag_word[1]           = cm;
      tag_word[0]           = cv;
      line_addr             = '0;
      line_addr[IDX_W+2 +: TAG_W] = ctag;
      line_addr[2 +: IDX_W] = idx;
   end

   always_comb begin
      res_load  = 1'b0;
      res_value = cdata;
      st_we     = 1'b0;
      tag_we    = 1'b0;
      data_we   = 1'b0;
      push_out  = 1'b0;
      nv        = cv;
      nm        = cm;
      if (line_ok) begin
         case (cmd)
            LC_SEARCH: begin
               if (!acc_wr) begin
                  res_load  = 1'b1;
                  res_value = tag_sel ? tag_word : cdata;
               end else if (tag_sel) begin
                  st_we  = 1'b1;
                  tag_we = 1'b1;
                  nv     = value_q[0];
                  nm     = value_q[1];
               end else begin
                  data_we = 1'b1;
               end
            end
            LC_INVAL: begin
               st_we = 1'b1;
               nv    = 1'b0;
               nm    = 1'b0;
            end
            LC_PUSH: begin
               st_we    = 1'b1;
               nm       = 1'b0;
               push_out = cv && cm;
            end
            LC_CLEAR: begin
               st_we    = 1'b1;
               nv       = 1'b0;
               nm       = 1'b0;
               push_out = cv && cm;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_addr  <= '0;
         wb_data  <= '0;
      end else begin
         wb_valid <= busy && push_out;
         if (busy && push_out) begin
            wb_addr <= line_addr;
            wb_data <= cdata;
         end
      end
   end

   assign value_rdata = value_q;

endmodule

// File: rtl/line_cmd_unit_chk.sv
module line_cmd_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [1:0]  reg_sel,
   input logic [31:0] reg_wdata,
   input logic [31:0] ctrl_rdata,
   input logic [31:0] srch_rdata,
   input logic        busy,
   input logic        wb_valid
);

   p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && !busy && (reg_sel == 2'd0 || reg_sel == 2'd1) && reg_wdata[0]) |=> busy);

   p_busy_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(ctrl_rdata[22:20]));

   p_drop_srch_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_sel == 2'd1) |=> $stable(srch_rdata[31:1]));

   p_drop_ctrl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && reg_sel == 2'd0) |=> $stable({ctrl_rdata[27:23], ctrl_rdata[19:1]}));

   p_wb_after_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> $past(busy));

   p_wb_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ctrl_rdata[25]);

   p_wb_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (ctrl_rdata[21:20] == 2'b11));

endmodule

bind line_cmd_unit line_cmd_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_we     (reg_we),
   .reg_sel    (reg_sel),
   .reg_wdata  (reg_wdata),
   .ctrl_rdata (ctrl_rdata),
   .srch_rdata (srch_rdata),
   .busy       (busy),
   .wb_valid   (wb_valid)
);

// File: tb/line_cmd_unit_bench.sv
`timescale 1ns/1ps
module line_cmd_unit_bench;

   localparam int IDX = 4;
   localparam int TG  = 8;
   localparam int DEP = 1 << IDX;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] ctrl_rdata, srch_rdata, value_rdata, wb_addr, wb_data;
   logic        busy, wb_valid;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;
   string cur_req = "R12";

   always #10 clk = ~clk;

   line_cmd_unit #(.IDX_W(IDX), .TAG_W(TG)) u_line_cmd_unit (
      .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata,
      .ctrl_rdata, .srch_rdata, .value_rdata, .busy,
      .wb_valid, .wb_addr, .wb_data
   );

   // behavioural reference model
   int          mt [2][DEP];
   logic [31:0] md [2][DEP];
   bit          mv [2][DEP];
   bit          mm [2][DEP];
   logic [31:0] m_ctrl, m_srch, m_val, m_wba, m_wbd;
   logic [2:0]  m_stat;
   bit          m_busy, m_wbv;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (mv[w, i]) begin
            mv[w][i] = 0; mm[w][i] = 0; mt[w][i] = 0; md[w][i] = 0;
         end
         m_ctrl = 0; m_srch = 0; m_val = 0; m_stat = 0;
         m_busy = 0; m_wbv = 0; m_wba = 0; m_wbd = 0;
      end else begin
         m_wbv = 0;
         if (m_busy) begin
            int  ix, wy, key;
            bit  hit, v, m;
            int  cm;
            cm = (m_ctrl >> 24) & 3;
            if (m_ctrl[26]) begin
               ix  = (m_srch >> 2) % DEP;
               key = (m_srch >> (IDX + 2)) % (1 << TG);
               hit = 0; wy = 0;
               for (int w = 0; w < 2; w++)
                  if (!hit && mv[w][ix] && mt[w][ix] == key) begin hit = 1; wy = w; end
            end else begin
               ix = (m_ctrl >> 2) % DEP; wy = m_ctrl[14]; hit = 1;
            end
            v = hit && mv[wy][ix];
            m = hit && mm[wy][ix];
            m_stat = {wy[0], m, v};
            if (hit) begin
               if (cm == 0) begin
                  if (!m_ctrl[27]) m_val = m_ctrl[16] ? ((mt[wy][ix] << 2) | (m << 1) | v) : md[wy][ix];
                  else if (m_ctrl[16]) begin
                     mt[wy][ix] = (m_val >> 2) % (1 << TG);
                     mm[wy][ix] = m_val[1]; mv[wy][ix] = m_val[0];
                  end else md[wy][ix] = m_val;
               end else begin
                  if (cm != 1 && v && m) begin
                     m_wbv = 1; m_wbd = md[wy][ix];
                     m_wba = (mt[wy][ix] << (IDX + 2)) | (ix << 2);
                  end
                  mm[wy][ix] = 0;
                  if (cm != 2) mv[wy][ix] = 0;
               end
            end
            m_busy = 0;
         end else if (reg_we) begin
            case (reg_sel)
               2'd0: begin m_ctrl = reg_wdata & 32'h0F01_7FFC; m_busy = reg_wdata[0]; end
               2'd1: begin m_srch = reg_wdata & ~32'h1; m_busy = reg_wdata[0]; end
               2'd2: m_val = reg_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "ctrl", ctrl_rdata, m_ctrl | {9'b0, m_stat, 19'b0, m_busy});
         chk(cur_req, "srch", srch_rdata, m_srch | {31'b0, m_busy});
         chk(cur_req, "value", value_rdata, m_val);
         chk(cur_req, "wb_valid", {31'b0, wb_valid}, {31'b0, m_wbv});
         if (m_wbv) begin
            chk(cur_req, "wb_addr", wb_addr, m_wba);
            chk(cur_req, "wb_data", wb_data, m_wbd);
         end
      end
   end

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic run(input logic [1:0] s, input logic [31:0] d);
      wr(s, d);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12", "reset ctrl", ctrl_rdata, 32'h0);
      chk("R12", "reset busy", {31'b0, busy}, 32'h0);
      run(2'd0, 32'h0401_0001);          // physical tag read, all lines invalid
      chk("R12", "empty miss status", {29'b0, ctrl_rdata[22:20]}, 32'h0);

      cur_req = "R4";
      run(2'd2, 32'hDEAD_BEEF);
      run(2'd0, 32'h0800_000D);          // data write way0 idx3
      run(2'd2, 32'h0000_016B);
      run(2'd0, 32'h0801_000D);          // tag write way0 idx3: tag 5A v1 m1
      run(2'd2, 32'h0000_0169);
      run(2'd0, 32'h0801_400D);          // tag write way1 idx3: tag 5A v1 m0

      cur_req = "R3";
      run(2'd0, 32'h0000_000D);
      chk("R3", "data read", value_rdata, 32'hDEAD_BEEF);
      chk("R10", "status way0", {29'b0, ctrl_rdata[22:20]}, 32'h3);
      run(2'd0, 32'h0001_400D);
      chk("R3", "tag read way1", value_rdata, 32'h0000_0169);
      chk("R10", "status way1", {29'b0, ctrl_rdata[22:20]}, 32'h5);

      cur_req = "R5";
      wr(2'd1, 32'h0000_168C);
      run(2'd0, 32'h0400_0001);
      chk("R5", "phys read", value_rdata, 32'hDEAD_BEEF);
      chk("R5", "way0 priority", {29'b0, ctrl_rdata[22:20]}, 32'h3);
      wr(2'd0, 32'h0401_0000);
      run(2'd1, 32'h0000_168D);          // start from search register
      chk("R5", "phys tag read", value_rdata, 32'h0000_016B);

      cur_req = "R6";
      run(2'd2, 32'h0BAD_F00D);
      wr(2'd1, 32'h0000_044C);
      run(2'd0, 32'h0C00_0001);          // physical data write, miss
      chk("R6", "miss status", {29'b0, ctrl_rdata[22:20]}, 32'h0);
      chk("R6", "miss value", value_rdata, 32'h0BAD_F00D);
      run(2'd0, 32'h0000_000D);
      chk("R6", "line unchanged", value_rdata, 32'hDEAD_BEEF);

      cur_req = "R8";
      wr(2'd1, 32'h0000_168C);
      run(2'd0, 32'h0600_0001);
      chk("R8", "push pulse", {31'b0, wb_valid}, 32'h1);
      chk("R8", "push addr", wb_addr, 32'h0000_168C);
      chk("R8", "push data", wb_data, 32'hDEAD_BEEF);
      run(2'd0, 32'h0600_0001);
      chk("R8", "clean push no pulse", {31'b0, wb_valid}, 32'h0);
      chk("R8", "push kept valid", {29'b0, ctrl_rdata[22:20]}, 32'h1);

      cur_req = "R9";
      run(2'd2, 32'h1234_5678);
      run(2'd0, 32'h0800_4015);
      run(2'd2, 32'h0000_00CF);
      run(2'd0, 32'h0801_4015);
      run(2'd0, 32'h0300_4015);
      chk("R9", "clear pulse", {31'b0, wb_valid}, 32'h1);
      chk("R9", "clear addr", wb_addr, 32'h0000_0CD4);
      chk("R9", "clear data", wb_data, 32'h1234_5678);
      chk("R10", "clear status", {29'b0, ctrl_rdata[22:20]}, 32'h7);
      run(2'd0, 32'h0001_4015);
      chk("R9", "cleared tag word", value_rdata, 32'h0000_00CC);

      cur_req = "R7";
      run(2'd0, 32'h0100_000D);
      run(2'd0, 32'h0001_000D);
      chk("R7", "invalidated tag word", value_rdata, 32'h0000_0168);

      cur_req = "R2";
      wr(2'd0, 32'h0071_004C);           // status bits set, index 19
      chk("R2", "status read-only", ctrl_rdata, 32'h0001_004C);
      run(2'd0, 32'h0001_004D);
      chk("R2", "high index bits unused", value_rdata, 32'h0000_0168);

      cur_req = "R11";
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_000D;
      @(negedge clk);
      chk("R1", "busy after start", {31'b0, busy}, 32'h1);
      reg_sel = 2'd2; reg_wdata = 32'hCAFE_F00D;
      @(negedge clk);
      reg_we = 1'b0;
      chk("R11", "value write dropped", value_rdata, 32'hDEAD_BEEF);
      chk("R1", "busy one cycle", {31'b0, busy}, 32'h0);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = 32'h0000_000D;
      @(negedge clk);
      reg_sel = 2'd1; reg_wdata = 32'h0000_0FF0;
      @(negedge clk);
      reg_we = 1'b0;
      chk("R11", "search write dropped", srch_rdata, 32'h0000_168C);
      repeat (2) @(negedge clk);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule